// File: doc/BRIEF.md
# ECC Error Interrupt Aggregator

This block collects the correctable (single-bit) and uncorrectable (double-bit) error indications of several ECC-protected memories and folds them into one shared pair of active-high interrupt lines. Every source owns one bit of a common interrupt mask. Software never writes the mask as a whole. One register address sets the mask bits written as 1, and a second address clears them. Reading either of these addresses returns the current mask.

Most sources present their error state as a level, and that level reaches the interrupt outputs directly. The cache source is handled differently. It latches a pending flag on each rising edge of its error inputs and holds that flag until software clears it. For this it has its own write-one-to-clear register, with separate bits for the single-bit flag and the double-bit flag. After reset every source is masked, so nothing interrupts until software opens the mask.

Top module: `eccIrqAggregator`

## Requirements
- R1: After reset every mask bit is 1 (masked), the cache pending flags are 0, and both interrupt outputs are low, even when source error levels are high.
- R2: A write to offset 0x94 sets each mask bit whose write-data bit is 1. Mask bits whose write-data bit is 0 keep their value. The new mask takes effect after the clock edge of the write.
- R3: A write to offset 0x98 clears each mask bit whose write-data bit is 1. Mask bits whose write-data bit is 0 keep their value.
- R4: A read of offset 0x94 or 0x98 returns the mask in bits [NUM_SRC-1:0], with 0 in every higher bit. A read of any other offset returns 0.
- R5: Mask bit i belongs to source i. Bit 0 is the cache source and bit 1 is the on-chip RAM source.
- R6: The single-bit output is the OR of the single-bit pending state of all unmasked sources. The double-bit output is formed the same way from the double-bit pending state. The two outputs are independent of each other.
- R7: For every source other than the cache, the pending state equals the input level in the same cycle.
- R8: The cache source sets a pending flag on a rising edge of its error input. The flag reaches the outputs after the first clock edge that samples the high level, and it stays set after the input falls. An input that stays high does not set the flag again once it has been cleared.
- R9: A write to offset 0xA8 clears the cache single-bit flag when data bit 15 is 1, and clears the cache double-bit flag when data bit 31 is 1. All other data bits have no effect. Clearing one flag leaves the other flag unchanged.
- R10: When a rising edge and a clear of the same cache flag fall in the same cycle, the flag ends up set.
- R11: A masked cache source still latches events. A flag latched while masked shows on the output as soon as the mask bit is cleared.
- R12: A write to any offset other than 0x94, 0x98 or 0xA8 changes neither the mask nor the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWr | input | 1 | Register write strobe, one cycle per write |
| regAddr | input | ADDR_W | Register byte offset for reads and writes |
| regWdata | input | DATA_W | Register write data |
| regRdata | output | DATA_W | Register read data, combinational from regAddr |
| sbErrLvl | input | NUM_SRC | Single-bit error indication per source |
| dbErrLvl | input | NUM_SRC | Double-bit error indication per source |
| irqSingle | output | 1 | Aggregated single-bit error interrupt, active high |
| irqDouble | output | 1 | Aggregated double-bit error interrupt, active high |

## Verification
The hardest case to reach from the ports is a cache event whose rising edge lands in exactly the same cycle as the write that clears that flag. To build it, the stimulus drives the error input high at the same falling clock edge that presents the clear write. It then checks that the interrupt stays asserted after the next edge. A second hard case is an event latched while the cache source is masked. The stimulus pulses the input under the mask and shows that the flag was held by unmasking the source afterwards. Mask and level combinations for the level-driven sources are swept completely.

// File: rtl/eccAggPkg.sv
package eccAggPkg;

  // Register offsets (byte addresses)
  localparam int unsigned MASK_SET_OFS  = 'h94;
  localparam int unsigned MASK_CLR_OFS  = 'h98;
  localparam int unsigned CACHE_CLR_OFS = 'hA8;

  // Strobes from the control decode into the datapath
  typedef struct packed {
    logic setStb;      // mask-set write this cycle
    logic clrStb;      // mask-clear write this cycle
    logic cacheClrSb;  // clear cache single-bit flag
    logic cacheClrDb;  // clear cache double-bit flag
  } eccStrobe_t;

endpackage

// File: rtl/eccIrqCtrl.sv
module eccIrqCtrl
  import eccAggPkg::*;
#(
  parameter int unsigned NUM_SRC    = 2,
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned CLR_SB_BIT = 15,
  parameter int unsigned CLR_DB_BIT = 31
) (
  input  logic               regWr,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [DATA_W-1:0]  regWdata,
  input  logic [NUM_SRC-1:0] maskVal,
  output eccStrobe_t         strb,
  output logic [NUM_SRC-1:0] wrBits,
  output logic [DATA_W-1:0]  regRdata
);

  localparam logic [ADDR_W-1:0] ADR_SET = ADDR_W'(MASK_SET_OFS);
  localparam logic [ADDR_W-1:0] ADR_CLR = ADDR_W'(MASK_CLR_OFS);
  localparam logic [ADDR_W-1:0] ADR_CCH = ADDR_W'(CACHE_CLR_OFS);

  logic hitSet, hitClr, hitCache;

  assign hitSet   = (regAddr == ADR_SET);
  assign hitClr   = (regAddr == ADR_CLR);
  assign hitCache = (regAddr == ADR_CCH);

  always_comb begin
    strb            = '0;
    strb.setStb     = regWr && hitSet;
    strb.clrStb     = regWr && hitClr;
    strb.cacheClrSb = regWr && hitCache && regWdata[CLR_SB_BIT];
    strb.cacheClrDb = regWr && hitCache && regWdata[CLR_DB_BIT];
  end

  assign wrBits = regWdata[NUM_SRC-1:0];

  // Read: the mask is visible at both mask addresses (R4)
  always_comb begin
    regRdata = '0;
    if (hitSet || hitClr) regRdata = DATA_W'(maskVal);
  end

  wire unusedWdata = ^regWdata;

endmodule

// File: rtl/eccIrqDatapath.sv
module eccIrqDatapath
  import eccAggPkg::*;
#(
  parameter int unsigned NUM_SRC   = 2,
  parameter int unsigned CACHE_IDX = 0
) (
  input  logic               clk,
  input  logic               rstN,
  input  eccStrobe_t         strb,
  input  logic [NUM_SRC-1:0] wrBits,
  input  logic [NUM_SRC-1:0] sbErrLvl,
  input  logic [NUM_SRC-1:0] dbErrLvl,
  output logic [NUM_SRC-1:0] maskVal,
  output logic               irqSingle,
  output logic               irqDouble
);

  logic [NUM_SRC-1:0] sbPend;
  logic [NUM_SRC-1:0] dbPend;

  // Shared mask: 1 = masked; all masked out of reset
  always_ff @(posedge clk) begin
    if (!rstN)             maskVal <= '1;
    else if (strb.setStb)  maskVal <= maskVal | wrBits;
    else if (strb.clrStb)  maskVal <= maskVal & ~wrBits;
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : gSrc
    if (i == CACHE_IDX) begin : gLatch
      logic sbPrev, dbPrev, sbHeld, dbHeld;
      always_ff @(posedge clk) begin
        if (!rstN) begin
          sbPrev <= 1'b0;
          dbPrev <= 1'b0;
          sbHeld <= 1'b0;
          dbHeld <= 1'b0;
        end else begin
          sbPrev <= sbErrLvl[i];
          dbPrev <= dbErrLvl[i];
          // a new edge outranks a clear in the same cycle
          sbHeld <= (sbErrLvl[i] & ~sbPrev) | (sbHeld & ~strb.cacheClrSb);
          dbHeld <= (dbErrLvl[i] & ~dbPrev) | (dbHeld & ~strb.cacheClrDb);
        end
      end
      assign sbPend[i] = sbHeld;
      assign dbPend[i] = dbHeld;
    end else begin : gLevel
      assign sbPend[i] = sbErrLvl[i];
      assign dbPend[i] = dbErrLvl[i];
    end
  end

  assign irqSingle = |(sbPend & ~maskVal);
  assign irqDouble = |(dbPend & ~maskVal);

  assert_mask_set_R2: assert property (@(posedge clk) disable iff (!rstN)
    strb.setStb |=> ((maskVal & $past(wrBits)) == $past(wrBits)));

  assert_mask_clr_R3: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrStb |=> ((maskVal & $past(wrBits)) == '0));

  assert_all_masked_quiet_R6: assert property (@(posedge clk) disable iff (!rstN)
    (&maskVal) |-> (!irqSingle && !irqDouble));

  assert_cache_latch_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sbErrLvl[CACHE_IDX]) |=> sbPend[CACHE_IDX]);

  assert_cache_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (dbPend[CACHE_IDX] && !strb.cacheClrDb) |=> dbPend[CACHE_IDX]);

  assert_edge_beats_clear_R10: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(dbErrLvl[CACHE_IDX]) && strb.cacheClrDb) |=> dbPend[CACHE_IDX]);

endmodule

// File: rtl/eccIrqAggregator.sv
module eccIrqAggregator
  import eccAggPkg::*;
#(
  parameter int unsigned NUM_SRC   = 2,
  parameter int unsigned CACHE_IDX = 0,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DATA_W    = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWr,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [DATA_W-1:0]  regWdata,
  output logic [DATA_W-1:0]  regRdata,
  input  logic [NUM_SRC-1:0] sbErrLvl,
  input  logic [NUM_SRC-1:0] dbErrLvl,
  output logic               irqSingle,
  output logic               irqDouble
);

  eccStrobe_t         strb;
  logic [NUM_SRC-1:0] wrBits;
  logic [NUM_SRC-1:0] maskVal;

  eccIrqCtrl #(
    .NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_ctrl (
    .regWr(regWr), .regAddr(regAddr), .regWdata(regWdata),
    .maskVal(maskVal), .strb(strb), .wrBits(wrBits), .regRdata(regRdata)
  );

  eccIrqDatapath #(
    .NUM_SRC(NUM_SRC), .CACHE_IDX(CACHE_IDX)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrBits(wrBits),
    .sbErrLvl(sbErrLvl), .dbErrLvl(dbErrLvl), .maskVal(maskVal),
    .irqSingle(irqSingle), .irqDouble(irqDouble)
  );

endmodule

// File: tb/eccIrqAggregator_bench.sv
`timescale 1ns/1ps
module eccIrqAggregator_bench;

  localparam int NS = 3;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          regWr = 1'b0;
  logic [7:0]    regAddr = '0;
  logic [31:0]   regWdata = '0;
  logic [31:0]   regRdata;
  logic [NS-1:0] sbErrLvl = '0;
  logic [NS-1:0] dbErrLvl = '0;
  logic          irqSingle, irqDouble;

  int nRun = 0;
  int nFail = 0;

  always #4 clk = ~clk;

  eccIrqAggregator #(.NUM_SRC(NS)) u_eccIrqAggregator (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .sbErrLvl(sbErrLvl),
    .dbErrLvl(dbErrLvl), .irqSingle(irqSingle), .irqDouble(irqDouble)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    regWr = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    regAddr = a;
    #1 d = regRdata;
  endtask

  task automatic setMask(input logic [NS-1:0] m);
    wr(8'h98, 32'(3'b111));
    wr(8'h94, 32'(m));
  endtask

  initial begin
    #(8 * 150000);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    logic [31:0] r;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    // R1: reset state with live error levels on level sources
    sbErrLvl = 3'b110; dbErrLvl = 3'b110;
    #1;
    check("R1 irqSingle", 32'(irqSingle), 0);
    check("R1 irqDouble", 32'(irqDouble), 0);
    rd(8'h94, r); check("R1 mask", r, 32'h7);
    sbErrLvl = '0; dbErrLvl = '0;

    // R12: unrelated offset write
    wr(8'hA0, 32'hFFFF_FFFF);
    rd(8'h98, r); check("R12 mask unchanged", r, 32'h7);

    // R2, R3, R4: mask set/clear sweeps
    for (int m = 0; m < 8; m++) begin
      setMask(3'(m));
      rd(8'h94, r); check("R2 set read 0x94", r, 32'(m));
      rd(8'h98, r); check("R4 read 0x98", r, 32'(m));
      wr(8'h94, 32'h7);
      wr(8'h98, 32'(m));
      rd(8'h94, r); check("R3 clear", r, 32'(7 & ~m));
    end
    rd(8'h9C, r); check("R4 other offset reads 0", r, 0);

    // R6, R7: full sweep over mask and level-source patterns
    for (int m = 0; m < 8; m++) begin
      setMask(3'(m));
      for (int s = 0; s < 4; s++) begin
        for (int d = 0; d < 4; d++) begin
          @(negedge clk);
          sbErrLvl = 3'(s << 1); dbErrLvl = 3'(d << 1);
          #1;
          check("R6 R7 irqSingle", 32'(irqSingle), 32'(|(3'(s << 1) & ~3'(m))));
          check("R6 R7 irqDouble", 32'(irqDouble), 32'(|(3'(d << 1) & ~3'(m))));
        end
      end
    end
    sbErrLvl = '0; dbErrLvl = '0;

    // R5: bit 1 is the on-chip RAM source
    wr(8'h94, 32'h7);
    wr(8'h98, 32'h2);
    sbErrLvl[1] = 1'b1; #1;
    check("R5 ram source bit 1", 32'(irqSingle), 1);
    sbErrLvl[1] = 1'b0;

    // R8: cache edge latch, timing and hold
    setMask(3'b000);
    @(negedge clk); sbErrLvl[0] = 1'b1; #1;
    check("R8 not before edge", 32'(irqSingle), 0);
    @(negedge clk); #1;
    check("R8 latched", 32'(irqSingle), 1);
    check("R8 double untouched", 32'(irqDouble), 0);
    sbErrLvl[0] = 1'b0;
    @(negedge clk); #1;
    check("R8 held after fall", 32'(irqSingle), 1);

    // R9: clear register bits
    wr(8'hA8, 32'h7FFF_7FFF);
    check("R9 other bits no effect", 32'(irqSingle), 1);
    wr(8'hA8, 32'h8000_0000);
    check("R9 db clear keeps sb", 32'(irqSingle), 1);
    wr(8'hA8, 32'h0000_8000);
    check("R9 sb cleared", 32'(irqSingle), 0);
    @(negedge clk); dbErrLvl[0] = 1'b1;
    @(negedge clk); dbErrLvl[0] = 1'b0; #1;
    check("R9 db latched", 32'(irqDouble), 1);
    wr(8'hA8, 32'h0000_8000);
    check("R9 sb clear keeps db", 32'(irqDouble), 1);
    wr(8'hA8, 32'h8000_0000);
    check("R9 db cleared", 32'(irqDouble), 0);

    // R10: edge and clear in the same cycle
    @(negedge clk);
    sbErrLvl[0] = 1'b1;
    regWr = 1'b1; regAddr = 8'hA8; regWdata = 32'h0000_8000;
    @(negedge clk); regWr = 1'b0; #1;
    check("R10 edge beats clear", 32'(irqSingle), 1);
    // R8: steady high level does not relatch
    wr(8'hA8, 32'h0000_8000);
    @(negedge clk); #1;
    check("R8 level no relatch", 32'(irqSingle), 0);
    sbErrLvl[0] = 1'b0;

    // R11: latch while masked, show on unmask
    wr(8'h94, 32'h1);
    @(negedge clk); sbErrLvl[0] = 1'b1;
    @(negedge clk); sbErrLvl[0] = 1'b0; #1;
    check("R11 masked quiet", 32'(irqSingle), 0);
    wr(8'h98, 32'h1);
    check("R11 shows on unmask", 32'(irqSingle), 1);
    wr(8'hA8, 32'h0000_8000);
    check("R11 cleared", 32'(irqSingle), 0);

    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule